// File: doc/BRIEF.md
# Bus Cycle Timeout and Interrupt Level Supervisor

This block watches an asynchronous, strobe-driven 16-bit processor bus and does three jobs for the CPU. First, it times every bus cycle. While the address strobe is low, a counter advances once per clock. If no device ends the cycle with a transfer acknowledge or a valid-peripheral-address response before a fixed limit, the block drives the bus-error input of the processor low. This lets the CPU leave a cycle that addressed nothing.

Second, it recognises interrupt-acknowledge cycles, which carry an all-ones function code. It answers each one with its own valid-peripheral-address response, so the processor takes the autovector for the level being served. Third, it merges seven active-low request lines into the 3-bit active-low priority level that the CPU samples. Each request line idles high, so several open-drain sources can share one line.

All storage resets synchronously. The timeout limit, the number of request lines, the function-code width, the acknowledge code and whether the level output is registered are all parameters.

Top module: `bg_supervisor`

## Requirements
- R1: The timeout counter is cleared on every clock edge at which the address strobe is sampled high. Two strobes separated by a single high sample each need a full timeout of their own.
- R2: `berr_n` goes low after the clock edge at which the strobe has been sampled low for the (TIMEOUT+1)-th consecutive time (193 with the default of 192). After exactly TIMEOUT low samples it is still high.
- R3: Once low, `berr_n` stays low while the strobe stays low. It returns high after the first clock edge at which the strobe is sampled high.
- R4: If `dtack_n` or `vpa_in_n` is sampled low at any edge of a strobe before the error has tripped, that strobe produces no bus error, however long it lasts.
- R5: When the strobe is low and `fc` equals all ones (3'b111), `avec_vpa_n` goes low after the next clock edge. It goes high after the first edge at which that condition no longer holds.
- R6: For any function code other than all ones, or while the strobe is high, `avec_vpa_n` stays high.
- R7: An interrupt-acknowledge cycle never produces a bus error, because the block's own autovector response ends the cycle.
- R8: Request line `irq_n[i]` (bit i, active low) stands for level i+1. `ipl_n` equals the bitwise inverse of the highest level whose line is low, and it appears one clock after the request pattern is sampled.
- R9: With every request line high, `ipl_n` is 3'b111 (level 0).
- R10: Whenever `irq_n[6]` (level 7) is low, `ipl_n` is 3'b000, whatever the other lines carry.
- R11: A low `rst_n` sampled at a clock edge drives `berr_n`, `avec_vpa_n` and `ipl_n` to all ones and clears the counter. A strobe still low after reset needs a full TIMEOUT+1 samples to trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| fc | input | FC_W (3) | Function code of the current cycle |
| dtack_n | input | 1 | Transfer acknowledge from other devices, active low |
| vpa_in_n | input | 1 | Valid-peripheral-address response from other devices, active low |
| irq_n | input | NUM_REQ (7) | Interrupt request lines, bit i is level i+1, active low |
| berr_n | output | 1 | Bus error to the CPU, active low |
| avec_vpa_n | output | 1 | Autovector valid-peripheral-address response, active low |
| ipl_n | output | LVL_W (3) | Encoded interrupt priority level, active low |

## Verification
The hardest case to reach is the exact edge of the timeout window. The bench has to separate a strobe that is low for 192 samples from one that is low for 193. It also has to show that one high sample in between restarts the count, and that a reset in mid-strobe does the same. The stimulus drives inputs on falling edges and counts rising edges one by one. It stops just short of the limit, checks, and then steps a single edge past it. The level encoder is swept through all 128 request patterns, and the expected level is worked out arithmetically for each one.

// File: rtl/bg_pkg.sv
package bg_pkg;

   // Response classes that terminate a strobe
   typedef struct packed {
      logic ack;       // transfer acknowledge from another device
      logic ext_vpa;   // valid-peripheral-address from another device
      logic own_vpa;   // this block's autovector response
   } bg_term_t;

   function automatic logic bg_any_term(input bg_term_t t);
      return t.ack | t.ext_vpa | t.own_vpa;
   endfunction

   function automatic int unsigned bg_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/bg_timeout.sv
module bg_timeout
   import bg_pkg::*;
#(
   parameter int unsigned TIMEOUT = 192
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     strobe_act,
   input  bg_term_t term,
   output logic     berr_o
);

   localparam int unsigned CNT_W = bg_width(TIMEOUT + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("bg_timeout: TIMEOUT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             acked_q;
   logic             berr_q;
   logic             term_now;
   logic             trip;

   assign term_now = bg_any_term(term);
   assign trip     = strobe_act && (cnt_q == LIMIT) && !acked_q && !term_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!strobe_act) begin
         cnt_q <= '0;
      end else if (cnt_q != LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acked_q <= 1'b0;
      end else begin
         acked_q <= strobe_act && (acked_q || term_now);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         berr_q <= 1'b0;
      end else begin
         berr_q <= strobe_act && (berr_q || trip);
      end
   end

   assign berr_o = berr_q;

   AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_act |=> (cnt_q == '0));                                      // R1
   AST_BERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(berr_q) |-> (cnt_q == LIMIT));                                 // R2
   AST_BERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_act |=> !berr_q);                                            // R3
   AST_ACK_SUPPRESSES: assert property (@(posedge clk) disable iff (!rst_n)
      (acked_q && !berr_q) |=> !berr_q);                                   // R4

endmodule

// File: rtl/bg_iack_detect.sv
module bg_iack_detect #(
   parameter int unsigned     FC_W      = 3,
   parameter logic [FC_W-1:0] IACK_CODE = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe_act,
   input  logic [FC_W-1:0] fc,
   output logic            iack_o
);

   if (FC_W < 1) begin : g_bad_fc
      $error("bg_iack_detect: FC_W must be at least 1");
   end

   logic iack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iack_q <= 1'b0;
      end else begin
         iack_q <= strobe_act && (fc == IACK_CODE);
      end
   end

   assign iack_o = iack_q;

   AST_VPA_ONLY_IACK: assert property (@(posedge clk) disable iff (!rst_n)
      iack_q |-> $past(strobe_act && (fc == IACK_CODE)));                  // R6
   AST_VPA_FOLLOWS_IACK: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_act && (fc == IACK_CODE)) |=> iack_q);                       // R5

endmodule

// File: rtl/bg_prio_enc.sv
module bg_prio_enc #(
   parameter int unsigned NUM_REQ    = 7,
   parameter int unsigned LVL_W      = 3,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_n,
   output logic [LVL_W-1:0]   lvl_n_o
);

   if (NUM_REQ < 1) begin : g_bad_req
      $error("bg_prio_enc: NUM_REQ must be at least 1");
   end
   if ((1 << LVL_W) < (NUM_REQ + 1)) begin : g_bad_lvl
      $error("bg_prio_enc: LVL_W too narrow for NUM_REQ");
   end

   logic [LVL_W-1:0] lvl;

   // Scan upward so the highest active request wins
   always_comb begin
      lvl = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (!req_n[i]) lvl = LVL_W'(i + 1);
      end
   end

   if (REGISTERED) begin : g_reg
      logic [LVL_W-1:0] lvl_n_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lvl_n_q <= '1;
         else        lvl_n_q <= ~lvl;
      end
      assign lvl_n_o = lvl_n_q;

      AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         !req_n[NUM_REQ-1] |=> (lvl_n_o == ~LVL_W'(NUM_REQ)));             // R10
      AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
         (&req_n) |=> (lvl_n_o == '1));                                    // R9
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign lvl_n_o = ~lvl;
   end

endmodule

// File: rtl/bg_supervisor.sv
module bg_supervisor
   import bg_pkg::*;
#(
   parameter int unsigned     TIMEOUT      = 192,
   parameter int unsigned     NUM_REQ      = 7,
   parameter int unsigned     LVL_W        = 3,
   parameter int unsigned     FC_W         = 3,
   parameter logic [FC_W-1:0] IACK_CODE    = '1,
   parameter bit              IPL_REGISTER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               as_n,
   input  logic [FC_W-1:0]    fc,
   input  logic               dtack_n,
   input  logic               vpa_in_n,
   input  logic [NUM_REQ-1:0] irq_n,
   output logic               berr_n,
   output logic               avec_vpa_n,
   output logic [LVL_W-1:0]   ipl_n
);

   if (LVL_W != bg_width(NUM_REQ + 1)) begin : g_bad_lvl_w
      $error("bg_supervisor: LVL_W must equal clog2(NUM_REQ+1)");
   end

   logic     strobe_act;
   logic     iack;
   logic     berr;
   bg_term_t term;

   assign strobe_act   = !as_n;
   assign term.ack     = !dtack_n;
   assign term.ext_vpa = !vpa_in_n;
   assign term.own_vpa = iack;

   bg_iack_detect #(
      .FC_W      (FC_W),
      .IACK_CODE (IACK_CODE)
   ) u_iack (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_act (strobe_act),
      .fc         (fc),
      .iack_o     (iack)
   );

   bg_timeout #(
      .TIMEOUT (TIMEOUT)
   ) u_timeout (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_act (strobe_act),
      .term       (term),
      .berr_o     (berr)
   );

   bg_prio_enc #(
      .NUM_REQ    (NUM_REQ),
      .LVL_W      (LVL_W),
      .REGISTERED (IPL_REGISTER)
   ) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_n   (irq_n),
      .lvl_n_o (ipl_n)
   );

   assign berr_n     = !berr;
   assign avec_vpa_n = !iack;

   AST_IACK_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!avec_vpa_n && berr_n) |=> berr_n);                                 // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (berr_n && avec_vpa_n));                                  // R11

endmodule

// File: tb/bg_supervisor_bench.sv
module bg_supervisor_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       as_n;
   logic [2:0] fc;
   logic       dtack_n;
   logic       vpa_in_n;
   logic [6:0] irq_n;
   logic       berr_n;
   logic       avec_vpa_n;
   logic [2:0] ipl_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;  // 125 MHz

   bg_supervisor u_bg_supervisor (
      .clk        (clk),
      .rst_n      (rst_n),
      .as_n       (as_n),
      .fc         (fc),
      .dtack_n    (dtack_n),
      .vpa_in_n   (vpa_in_n),
      .irq_n      (irq_n),
      .berr_n     (berr_n),
      .avec_vpa_n (avec_vpa_n),
      .ipl_n      (ipl_n)
   );

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_ipl(input int pat);
      int lvl = 0;
      for (int i = 0; i < 7; i++) if (((pat >> i) & 1) == 0) lvl = i + 1;
      return (~lvl) & 7;
   endfunction

   initial begin
      #1_200_000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; as_n = 1'b1; fc = 3'd1; dtack_n = 1'b1; vpa_in_n = 1'b1;
      irq_n = 7'h00;
      @(negedge clk);
      tick(3);
      // R11: reset state, even with requests and a strobe pending
      as_n = 1'b0;
      tick(1);
      check("R11 berr_n in reset", berr_n, 1);
      check("R11 avec_vpa_n in reset", avec_vpa_n, 1);
      check("R11 ipl_n in reset", ipl_n, 7);
      as_n = 1'b1; irq_n = 7'h7f;
      rst_n = 1'b1;
      tick(2);
      check("R9 idle level", ipl_n, 7);

      // R2: exact limit
      as_n = 1'b0;
      tick(192);
      check("R2 no error at 192", berr_n, 1);
      tick(1);
      check("R2 error at 193", berr_n, 0);
      tick(20);
      check("R3 error held", berr_n, 0);
      dtack_n = 1'b0;
      tick(1);
      dtack_n = 1'b1;
      check("R3 late ack keeps error", berr_n, 0);
      as_n = 1'b1;
      tick(1);
      check("R3 error released", berr_n, 1);

      // R1: one high sample restarts the count
      as_n = 1'b0; tick(150);
      as_n = 1'b1; tick(1);
      as_n = 1'b0; tick(150);
      check("R1 count restarted", berr_n, 1);
      tick(42);
      check("R1 fresh 192", berr_n, 1);
      tick(1);
      check("R1 fresh 193", berr_n, 0);
      as_n = 1'b1; tick(2);

      // R4: acknowledge suppresses the timeout
      as_n = 1'b0; tick(10);
      dtack_n = 1'b0; tick(1); dtack_n = 1'b1;
      tick(300);
      check("R4 ack suppresses", berr_n, 1);
      as_n = 1'b1; tick(1);
      as_n = 1'b0; tick(192);
      vpa_in_n = 1'b0; tick(1); vpa_in_n = 1'b1;
      tick(100);
      check("R4 ext vpa at last edge suppresses", berr_n, 1);
      as_n = 1'b1; tick(2);

      // R5 / R7: interrupt acknowledge
      fc = 3'b111; as_n = 1'b0;
      check("R5 not before edge", avec_vpa_n, 1);
      tick(1);
      check("R5 vpa asserted", avec_vpa_n, 0);
      tick(300);
      check("R7 no error in iack", berr_n, 1);
      check("R5 vpa held", avec_vpa_n, 0);
      as_n = 1'b1; tick(1);
      check("R5 vpa released", avec_vpa_n, 1);
      tick(3);
      check("R6 fc all ones, strobe high", avec_vpa_n, 1);

      // R6: other function codes
      for (int f = 0; f < 7; f++) begin
         fc = 3'(f); as_n = 1'b0;
         tick(3);
         check("R6 non-iack code", avec_vpa_n, 1);
         as_n = 1'b1; tick(1);
      end
      fc = 3'd1;

      // R11: reset in mid-strobe restarts the window
      as_n = 1'b0; tick(100);
      rst_n = 1'b0; tick(1);
      check("R11 berr_n during reset", berr_n, 1);
      rst_n = 1'b1;
      tick(192);
      check("R11 no error 192 after reset", berr_n, 1);
      tick(1);
      check("R11 error 193 after reset", berr_n, 0);
      as_n = 1'b1; tick(1);

      // R8 / R9 / R10: exhaustive request sweep
      for (int p = 0; p < 128; p++) begin
         irq_n = 7'(p);
         tick(1);
         if (p == 127)              check("R9 no request", ipl_n, exp_ipl(p));
         else if (((p >> 6) & 1) == 0) check("R10 level 7 wins", ipl_n, exp_ipl(p));
         else                       check("R8 priority level", ipl_n, exp_ipl(p));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule